// File: doc/BRIEF.md
# Multi-User Interprocessor Mailbox

This block lets several processors pass 32-bit messages to one another through a shared, memory-mapped register window. It holds a set of small message FIFOs. Each FIFO is reached through its own message word: a write pushes a message and a read pops the oldest one. Alongside each FIFO sit a full flag and an occupancy count, so software can poll the FIFO without disturbing it.

Every interrupt destination ("user") has its own event-status word and event-enable word. Each FIFO reports two kinds of event into every user's status word. A new-message event fires on each accepted push. A not-full event fires when a pop takes the FIFO out of the full state. Software acknowledges an event by writing a 1 to its status bit. A user's interrupt line is raised while any event is both pending and enabled.

A parameter selects one of two interrupt register layouts. The compact layout gives each user a plain enable word that software rewrites in full. The set/clear layout gives each user separate enable-set and enable-clear words, so a bit can be changed without a read-modify-write. The bus port is a single-cycle register port: read data is valid in the same cycle as the request, and any pop takes effect at that cycle's clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: Offset 0x000 reads the fixed value of parameter REV_ID (default 0x0000_0102), and writes to it have no effect.
- R2: A write to the message word of FIFO m (0x040 + 4*m) appends a message, and a read of it returns and removes the oldest one, in first-in first-out order. The count word (0x0C0 + 4*m) reads the number of stored messages. The full word (0x080 + 4*m) reads 1 when the count equals DEPTH and 0 otherwise. All of these read 0 after reset.
- R3: A write to a FIFO that already holds DEPTH messages is dropped: the count stays at DEPTH and later reads return the earlier messages unchanged.
- R4: A read of an empty FIFO's message word returns 0 and leaves its count at 0 and all status bits unchanged.
- R5: Every accepted push into FIFO m sets bit 2*m of every user's status word.
- R6: A pop from a FIFO m that held DEPTH messages sets bit 2*m+1 of every user's status word. A pop from a FIFO that was not full does not set that bit.
- R7: Writing 1s to a status word clears exactly those bits, and the next read of the word returns the cleared value. Bits written as 0 are kept.
- R8: Interrupt line u is high exactly when some bit is set both in user u's status word and in user u's enable word. All interrupt lines are low after reset.
- R9: In the compact layout, user u's status word is at 0x100 + 8*u and its enable word is at 0x104 + 8*u. A write replaces the enable word, which reads back limited to its 2*NUM_FIFOS implemented bits. Disabling is done by writing back a value with those bits at 0.
- R10: In the set/clear layout, user u's status word is at 0x104 + 0x10*u, its enable-set word is at 0x108 + 0x10*u and its enable-clear word is at 0x10C + 0x10*u. Writing 1s to enable-set turns on exactly those bits, and writing 1s to enable-clear turns off exactly those bits. Both words read back the current enable value.
- R11: Offsets that map to no register read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the request cycle |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
The hardest case to reach from the ports is the not-full event. It needs a FIFO filled to exactly DEPTH, then a pop, and its bit must be separated from the new-message bit set by the fills. The directed part of the bench fills a FIFO to the limit and pushes once more to show the write is dropped. It then acknowledges all pending events, pops once, and pops again to show that only the first pop raises the event. After that, a long run of random accesses to both layouts is checked cycle by cycle against a queue-based model. The random run is biased toward message words, so FIFOs often pass through full and empty while enables and acknowledges change around them.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NUM_FIFOS = 4,
  parameter int NUM_USERS = 2,
  parameter int DEPTH = 4,
  parameter int DW = 32,
  parameter int AW = 9,
  parameter bit SETCLR_LAYOUT = 1'b0,
  parameter logic [DW-1:0] REV_ID = 'h0000_0102
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic [NUM_USERS-1:0] irq
);
  localparam int EVB = 2 * NUM_FIFOS;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic hit(input logic [AW-1:0] a, input int off);
    return ({{(32-AW){1'b0}}, a} == 32'(off));
  endfunction

  function automatic int st_off(input int u);
    return SETCLR_LAYOUT ? ('h104 + 16 * u) : ('h100 + 8 * u);
  endfunction

  function automatic int en_off(input int u);
    return SETCLR_LAYOUT ? ('h108 + 16 * u) : ('h104 + 8 * u);
  endfunction

  function automatic int clr_off(input int u);
    return 'h10C + 16 * u;
  endfunction

  wire wr = bus_sel & bus_we;
  wire rd = bus_sel & ~bus_we;

  logic [NUM_FIFOS-1:0][CW-1:0] fcnt;
  logic [NUM_FIFOS-1:0][DW-1:0] head;
  logic [NUM_FIFOS-1:0]         full;
  logic [EVB-1:0]               ev;
  logic [NUM_USERS-1:0][EVB-1:0] stat;
  logic [NUM_USERS-1:0][EVB-1:0] enab;

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    wire is_full  = (cnt == CW'(DEPTH));
    wire is_empty = (cnt == '0);
    wire msg_hit  = hit(bus_addr, 'h40 + 4 * m);
    wire push     = wr & msg_hit & ~is_full;
    wire pop      = rd & msg_hit & ~is_empty;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (push) begin
          wp  <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
          cnt <= cnt + 1'b1;
        end
        if (pop) begin
          rp  <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
          cnt <= cnt - 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (push) slots[wp] <= bus_wdata;
    end

    assign fcnt[m]     = cnt;
    assign full[m]     = is_full;
    assign head[m]     = is_empty ? '0 : slots[rp];
    assign ev[2*m]     = push;
    assign ev[2*m + 1] = pop & is_full;
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    logic [EVB-1:0] st, en;
    wire [EVB-1:0] wbits = bus_wdata[EVB-1:0];
    wire st_hit  = hit(bus_addr, st_off(u));
    wire en_hit  = hit(bus_addr, en_off(u));
    wire clr_hit = SETCLR_LAYOUT && hit(bus_addr, clr_off(u));
    wire [EVB-1:0] ack = (wr & st_hit) ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= '0;
        en <= '0;
      end else begin
        st <= (st & ~ack) | ev;
        if (wr & en_hit)
          en <= SETCLR_LAYOUT ? (en | wbits) : wbits;
        else if (wr & clr_hit)
          en <= en & ~wbits;
      end
    end

    assign stat[u] = st;
    assign enab[u] = en;
    assign irq[u]  = |(st & en);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, 0)) bus_rdata = REV_ID;
    for (int m = 0; m < NUM_FIFOS; m++) begin
      if (hit(bus_addr, 'h40 + 4 * m)) bus_rdata = head[m];
      if (hit(bus_addr, 'h80 + 4 * m)) bus_rdata = {{(DW-1){1'b0}}, full[m]};
      if (hit(bus_addr, 'hC0 + 4 * m)) bus_rdata = DW'(fcnt[m]);
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (hit(bus_addr, st_off(u))) bus_rdata[EVB-1:0] = stat[u];
      if (hit(bus_addr, en_off(u)) || (SETCLR_LAYOUT && hit(bus_addr, clr_off(u))))
        bus_rdata[EVB-1:0] = enab[u];
    end
  end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int NUM_FIFOS = 4,
  parameter int NUM_USERS = 2,
  parameter int DEPTH = 4,
  parameter int DW = 32,
  parameter int AW = 9,
  parameter logic [DW-1:0] REV_ID = 'h0000_0102,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               bus_sel,
  input logic                               bus_we,
  input logic [AW-1:0]                      bus_addr,
  input logic [DW-1:0]                      bus_rdata,
  input logic [NUM_USERS-1:0]               irq,
  input logic [NUM_FIFOS-1:0][CW-1:0]       fcnt,
  input logic [NUM_USERS-1:0][2*NUM_FIFOS-1:0] stat
);
  wire rd = bus_sel & ~bus_we;
  wire wr = bus_sel & bus_we;

  assert_rev_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == AW'(0) |-> bus_rdata == REV_ID);

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == AW'('h004) |-> bus_rdata == '0);

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_f
    wire msg = bus_addr == AW'('h40 + 4 * m);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt[m] <= CW'(DEPTH));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr && msg && fcnt[m] == CW'(DEPTH) |=> fcnt[m] == CW'(DEPTH));

    assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd && msg && fcnt[m] == '0 |-> bus_rdata == '0);

    assert_empty_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd && msg && fcnt[m] == '0 |=> fcnt[m] == '0);

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
      assert_newmsg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr && msg && fcnt[m] != CW'(DEPTH) |=> stat[u][2*m]);

      assert_notfull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd && msg && fcnt[m] == CW'(DEPTH) |=> stat[u][2*m+1]);
    end
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_irq
    assert_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[u] |-> stat[u] != '0);
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .NUM_FIFOS(NUM_FIFOS), .NUM_USERS(NUM_USERS), .DEPTH(DEPTH),
  .DW(DW), .AW(AW), .REV_ID(REV_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .fcnt(fcnt), .stat(stat)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  localparam int NF = 4;
  localparam int NU = 2;
  localparam int D  = 4;
  localparam logic [31:0] REV = 32'h0000_0102;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1;
  logic [NU-1:0] irq0, irq1;
  int total = 0;
  int bad = 0;
  bit run = 1'b0;

  always #4 clk = ~clk;

  ipc_mailbox #(.SETCLR_LAYOUT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[0]), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd0), .irq(irq0));

  ipc_mailbox #(.SETCLR_LAYOUT(1'b1)) u_dut_sc (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel[1]), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd1), .irq(irq1));

  logic [31:0] mq [8][$];
  logic [7:0] mst [2][NU];
  logic [7:0] men [2][NU];

  task automatic check(string tag, int a, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int k, int a);
    if (a == 0) return REV;
    for (int m = 0; m < NF; m++) begin
      if (a == 'h40 + 4*m) return (mq[k*NF+m].size() > 0) ? mq[k*NF+m][0] : 32'h0;
      if (a == 'h80 + 4*m) return (mq[k*NF+m].size() == D) ? 32'h1 : 32'h0;
      if (a == 'hC0 + 4*m) return 32'(mq[k*NF+m].size());
    end
    for (int u = 0; u < NU; u++) begin
      if (k == 0) begin
        if (a == 'h100 + 8*u) return {24'h0, mst[k][u]};
        if (a == 'h104 + 8*u) return {24'h0, men[k][u]};
      end else begin
        if (a == 'h104 + 16*u) return {24'h0, mst[k][u]};
        if (a == 'h108 + 16*u || a == 'h10C + 16*u) return {24'h0, men[k][u]};
      end
    end
    return 32'h0;
  endfunction

  task automatic model_apply(int k, bit w, int a, logic [31:0] d);
    for (int m = 0; m < NF; m++) begin
      if (a == 'h40 + 4*m) begin
        if (w) begin
          if (mq[k*NF+m].size() < D) begin
            mq[k*NF+m].push_back(d);
            for (int u = 0; u < NU; u++) mst[k][u][2*m] = 1'b1;
          end
        end else if (mq[k*NF+m].size() > 0) begin
          if (mq[k*NF+m].size() == D)
            for (int u = 0; u < NU; u++) mst[k][u][2*m+1] = 1'b1;
          void'(mq[k*NF+m].pop_front());
        end
      end
    end
    if (w) begin
      for (int u = 0; u < NU; u++) begin
        if (k == 0) begin
          if (a == 'h100 + 8*u) mst[k][u] &= ~d[7:0];
          if (a == 'h104 + 8*u) men[k][u] = d[7:0];
        end else begin
          if (a == 'h104 + 16*u) mst[k][u] &= ~d[7:0];
          if (a == 'h108 + 16*u) men[k][u] |= d[7:0];
          if (a == 'h10C + 16*u) men[k][u] &= ~d[7:0];
        end
      end
    end
  endtask

  task automatic op(int k, bit w, int a, logic [31:0] d, string tag);
    logic [31:0] exp;
    @(negedge clk);
    sel = '0;
    sel[k] = 1'b1;
    we = w;
    addr = 9'(a);
    wdata = d;
    #1;
    if (!w) begin
      exp = exp_read(k, a);
      check(tag, a, (k == 0) ? rd0 : rd1, exp);
    end
    @(posedge clk);
    #1;
    model_apply(k, w, a, d);
    sel = '0;
  endtask

  always @(negedge clk) begin
    if (run) begin
      for (int u = 0; u < NU; u++) begin
        check("R8 irq legacy", u, {31'h0, irq0[u]}, {31'h0, |(mst[0][u] & men[0][u])});
        check("R8 irq setclr", u, {31'h0, irq1[u]}, {31'h0, |(mst[1][u] & men[1][u])});
      end
    end
  end

  function automatic int pick_addr(int k);
    int r = $urandom % 10;
    int i = $urandom % NF;
    int u = $urandom % NU;
    if (r < 5) return 'h40 + 4*i;
    if (r == 5) return 'hC0 + 4*i;
    if (r == 6) return 'h80 + 4*i;
    if (r == 7) return (k == 0) ? 'h100 + 8*u : 'h104 + 16*u;
    if (r == 8) return (k == 0) ? 'h104 + 8*u : (($urandom % 2) ? 'h108 + 16*u : 'h10C + 16*u);
    return 'h004;
  endfunction

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++)
      for (int u = 0; u < NU; u++) begin
        mst[k][u] = '0;
        men[k][u] = '0;
      end
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset irq", 0, {30'h0, irq1, irq0}, 32'h0);
    rst_n = 1'b1;
    run = 1'b1;

    for (int k = 0; k < 2; k++)
      for (int m = 0; m < NF; m++) begin
        op(k, 0, 'hC0 + 4*m, 0, "R2 reset count");
        op(k, 0, 'h80 + 4*m, 0, "R2 reset full");
      end
    op(0, 0, 'h100, 0, "R7 reset status");

    op(0, 0, 'h000, 0, "R1 rev");
    op(0, 1, 'h000, 32'hDEAD_BEEF, "R1");
    op(0, 0, 'h000, 0, "R1 rev after write");
    op(0, 0, 'h004, 0, "R11 unmapped");
    op(0, 0, 'h110, 0, "R11 unmapped");
    op(0, 1, 'h004, 32'hFFFF_FFFF, "R11");
    op(0, 0, 'h004, 0, "R11 write ignored");
    op(0, 0, 'h1FC, 0, "R11 unmapped");

    op(0, 1, 'h44, 32'h1111_0001, "R2");
    op(0, 1, 'h44, 32'h1111_0002, "R2");
    op(0, 1, 'h44, 32'h1111_0003, "R2");
    op(0, 0, 'hC4, 0, "R2 count");
    op(0, 0, 'h84, 0, "R2 full");
    op(0, 0, 'h100, 0, "R5 user0 newmsg");
    op(0, 0, 'h108, 0, "R5 user1 newmsg");
    op(0, 1, 'h100, 32'h4, "R7");
    op(0, 0, 'h100, 0, "R7 cleared");
    op(0, 0, 'h108, 0, "R7 other user kept");
    for (int i = 0; i < 3; i++) op(0, 0, 'h44, 0, "R2 order");
    op(0, 0, 'hC4, 0, "R2 count drained");

    op(0, 1, 'h104, 32'h0000_0001, "R9");
    for (int i = 0; i < D; i++) op(0, 1, 'h40, 32'hA0 + i, "R3");
    op(0, 0, 'h80, 0, "R3 full");
    op(0, 1, 'h40, 32'hBAD0, "R3");
    op(0, 0, 'hC0, 0, "R3 count held");
    op(0, 1, 'h100, 32'hFF, "R7");
    op(0, 1, 'h108, 32'hFF, "R7");
    op(0, 0, 'h40, 0, "R6 pop from full");
    op(0, 0, 'h100, 0, "R6 notfull set");
    op(0, 1, 'h100, 32'h2, "R7");
    op(0, 0, 'h40, 0, "R6 pop not full");
    op(0, 0, 'h100, 0, "R6 notfull not set");
    op(0, 0, 'h108, 0, "R6 user1");
    op(0, 0, 'h40, 0, "R3 content");
    op(0, 0, 'h40, 0, "R3 content");
    op(0, 1, 'h100, 32'hFF, "R7");
    op(0, 0, 'h40, 0, "R4 empty read");
    op(0, 0, 'hC0, 0, "R4 count");
    op(0, 0, 'h100, 0, "R4 status");

    op(0, 1, 'h104, 32'hFFFF_FFFF, "R9");
    op(0, 0, 'h104, 0, "R9 readback masked");
    op(0, 1, 'h104, 32'h0000_0005, "R9");
    op(0, 0, 'h104, 0, "R9 writeback disable");
    op(0, 1, 'h48, 32'h77, "R8");
    op(0, 1, 'h10C, 32'h10, "R8");
    op(0, 0, 'h10C, 0, "R9 user1 enable");

    op(1, 0, 'h100, 0, "R11 setclr unmapped");
    op(1, 1, 'h108, 32'h3, "R10");
    op(1, 0, 'h108, 0, "R10 set readback");
    op(1, 0, 'h10C, 0, "R10 clr readback");
    op(1, 1, 'h108, 32'h10, "R10");
    op(1, 1, 'h10C, 32'h1, "R10");
    op(1, 0, 'h108, 0, "R10 after clear");
    op(1, 1, 'h48, 32'h55, "R10");
    op(1, 0, 'h104, 0, "R5 setclr status");
    op(1, 0, 'h114, 0, "R5 setclr user1");
    op(1, 1, 'h118, 32'hF0, "R10");
    op(1, 0, 'h11C, 0, "R10 user1");
    op(1, 1, 'h104, 32'h10, "R7");
    op(1, 0, 'h104, 0, "R7 setclr cleared");

    for (int i = 0; i < 600; i++) begin
      int k = i % 2;
      int a = pick_addr(k);
      bit w = ($urandom % 2) == 1;
      op(k, w, a, $urandom, "R2 random");
    end

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule